// File: doc/BRIEF.md
# Programmable Audio Serial Frame Transmitter

This block turns parallel left/right audio samples into a serial frame. It drives up to four serial data lanes together with a bit clock and a word-select line. A frame is a programmable number of bit periods long. Within it, the left and right channel data each start at a frame bit position set by software. A start/stop index limits the transmitted part of each sample. That part is sent either most-significant-bit first or least-significant-bit first. Every other bit in the frame is sent as zero, so the stream can feed a converter wider than the sample.

Samples arrive on a valid/ready interface, and each lane has its own left and right sample in one flat vector. A new sample set is accepted only on the cycle that launches frame bit 0. If none is offered, the previous set is sent again. The configuration also selects:
- 16-bit or 32-bit samples;
- mono or stereo;
- the number of active lanes;
- the word-select level that marks a frame start;
- whether word-select is a 50% wave or a one-bit pulse;
- which bit-clock edge launches data.

The bit clock runs at half the system clock. A frame shorter than the mode needs is reported as a configuration error, and the transmitter stays idle while the error is present.

Top module: `aud_frame_tx`

## Requirements
- R1: With `cfg_lsb_first`=0, lane data bit `top` (15 in 16-bit mode, 31 in 32-bit mode) is sent at frame bit `cfg_left_pos` (or `cfg_right_pos`). It is followed by bits of decreasing index down to and including bit `cfg_cut_idx`.
- R2: With `cfg_lsb_first`=1, bit `cfg_cut_idx` is sent at the channel's start position. It is followed by bits of increasing index up to and including bit `top`.
- R3: Every frame bit outside the left and right slices is sent as 0, and slice bits past the frame end are dropped.
- R4: With `cfg_wide`=0 only bits 15..0 of each 32-bit lane field are used. With `cfg_wide`=1 bits up to 31 are sent.
- R5: A frame lasts `cfg_frame_len` bit periods. With `cfg_ws_pulse`=0, word-select sits at the start level for frame bits 0..floor(len/2)-1 and at the opposite level for the rest. The start level is 1 when `cfg_ws_start_high`=1 and 0 otherwise.
- R6: With `cfg_ws_pulse`=1, word-select sits at the start level only during frame bit 0.
- R7: The bit clock has half the `clk` rate. Word-select and data change only when the bit clock moves to level `cfg_launch_rise`: a fall when it is 0, a rise when it is 1. The receiver samples on the opposite edge. When idle, the bit clock rests at `cfg_launch_rise`, word-select at the non-start level and the data lanes at 0.
- R8: Lanes 0..`cfg_lanes` are active (code 0 = one lane, 3 = four lanes). Every other lane stays at 0.
- R9: With `cfg_stereo`=0, each active lane sends its left sample in both the left and the right slices.
- R10: `s_ready` is high only on the cycle that launches frame bit 0. A sample set accepted there is sent in that frame. A frame with no accepted set repeats the last one.
- R11: `cfg_err` is high when `cfg_frame_len` is below 36 in 32-bit stereo mode, or below 13 in every other mode. While it is high, no frame is sent, `s_ready` stays low and the outputs hold their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmission enable |
| cfg_ws_start_high | input | 1 | Word-select level that marks a frame start |
| cfg_launch_rise | input | 1 | 1: launch data on the rising bit-clock edge |
| cfg_ws_pulse | input | 1 | 1: word-select is a one-bit pulse |
| cfg_lsb_first | input | 1 | Bit order of the slice |
| cfg_wide | input | 1 | 1: 32-bit samples, 0: 16-bit |
| cfg_stereo | input | 1 | 1: stereo, 0: mono |
| cfg_lanes | input | 2 | Active lane count minus one |
| cfg_left_pos | input | 9 | Frame bit of the first left data bit |
| cfg_right_pos | input | 9 | Frame bit of the first right data bit |
| cfg_cut_idx | input | 5 | Start/stop sample bit index |
| cfg_frame_len | input | 10 | Frame length in bits |
| s_valid | input | 1 | Sample set offered |
| s_ready | output | 1 | Sample set taken this cycle when valid |
| s_left | input | 128 | Left samples, lane n in bits 32n+31..32n |
| s_right | input | 128 | Right samples, lane n in bits 32n+31..32n |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word-select |
| sd | output | 4 | Serial data lanes |
| cfg_err | output | 1 | Frame length below the mode minimum |

## Verification
The hardest condition to reach from the ports is the frame boundary where a sample set hands over. The new sample must be used starting with bit 0 of the frame in which it is accepted, and a frame with no offer must repeat the old sample. The bench holds `s_valid` until it sees `s_ready`, then drops it. A passive monitor rebuilds each frame from the sampling edges of the bit clock. The bench compares that frame, and the one after it with no offer, against a frame assembled from the slice rules. The error threshold is probed on both sides: 35 and 36 bits in 32-bit stereo, 12 and 13 bits in mono.

// File: rtl/aftx_pkg.sv
package aftx_pkg;

    localparam int SMP_W = 32;
    localparam int POS_W = 9;
    localparam int LEN_W = 10;
    localparam int IDX_W = 5;

    typedef struct packed {
        logic             ws_hi;
        logic             rise_launch;
        logic             ws_pulse;
        logic             lsb_first;
        logic             wide;
        logic             stereo;
        logic [1:0]       lanes;
        logic [POS_W-1:0] lpos;
        logic [POS_W-1:0] rpos;
        logic [IDX_W-1:0] cut;
        logic [LEN_W-1:0] flen;
    } cfg_t;

    typedef struct packed {
        logic hit;
        logic val;
    } slot_t;

    function automatic logic [LEN_W-1:0] min_len(cfg_t c);
        return (c.wide && c.stereo) ? LEN_W'(36) : LEN_W'(13);
    endfunction

    // Decide whether frame bit b belongs to a slice starting at pos,
    // and if so which sample bit it carries.
    function automatic slot_t slot_bit(logic [SMP_W-1:0] smp, logic [LEN_W-1:0] b,
                                       logic [POS_W-1:0] pos, cfg_t c);
        logic [IDX_W-1:0] top;
        logic [LEN_W:0]   k;
        logic [5:0]       span;
        logic [5:0]       idx;
        slot_t            r;
        top  = c.wide ? IDX_W'(31) : IDX_W'(15);
        span = (c.cut > top) ? 6'd0 : ({1'b0, top} - {1'b0, c.cut} + 6'd1);
        r    = '0;
        k    = '0;
        idx  = '0;
        if ({1'b0, b} >= {2'b00, pos}) begin
            k = {1'b0, b} - {2'b00, pos};
            if (k < {5'b0, span}) begin
                idx   = c.lsb_first ? (6'(c.cut) + 6'(k)) : (6'(top) - 6'(k));
                r.hit = 1'b1;
                r.val = smp[idx[4:0]];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/aftx_timing.sv
module aftx_timing
    import aftx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  cfg_t             cfg,
    output logic             launch,
    output logic [LEN_W-1:0] nxt,
    output logic [LEN_W-1:0] cnt,
    output logic             ws,
    output logic             sck
);

    logic ph;
    logic first_part;

    assign launch     = run & ph;
    assign nxt        = (cnt >= cfg.flen - LEN_W'(1)) ? '0 : cnt + LEN_W'(1);
    assign first_part = cfg.ws_pulse ? (nxt == '0) : (nxt < (cfg.flen >> 1));
    assign sck        = ph ^ cfg.rise_launch;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph  <= 1'b0;
            cnt <= '1;
            ws  <= ~cfg.ws_hi;
        end else begin
            ph <= ~ph;
            if (ph) begin
                cnt <= nxt;
                ws  <= first_part ? cfg.ws_hi : ~cfg.ws_hi;
            end
        end
    end

    assert_ws_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && ws != $past(ws)) |-> (sck == cfg.rise_launch));

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
        (launch && $stable(cfg.flen)) |=> (cnt < cfg.flen));

    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
        (run && cfg.ws_pulse && ws == cfg.ws_hi && $stable(cfg.ws_hi)) |-> (cnt == '0));

endmodule

// File: rtl/aftx_lane.sv
module aftx_lane
    import aftx_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             launch,
    input  logic             take,
    input  logic [LEN_W-1:0] nxt,
    input  cfg_t             cfg,
    input  logic [SMP_W-1:0] new_l,
    input  logic [SMP_W-1:0] new_r,
    output logic             sd
);

    logic [SMP_W-1:0] held_l, held_r;
    logic [SMP_W-1:0] cur_l, cur_r, right_src;
    logic             active;
    slot_t            sl, sr;

    assign active    = (LANE <= int'(cfg.lanes));
    assign cur_l     = take ? new_l : held_l;
    assign cur_r     = take ? new_r : held_r;
    assign right_src = cfg.stereo ? cur_r : cur_l;
    assign sl        = slot_bit(cur_l, nxt, cfg.lpos, cfg);
    assign sr        = slot_bit(right_src, nxt, cfg.rpos, cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_l <= '0;
            held_r <= '0;
        end else if (take) begin
            held_l <= new_l;
            held_r <= new_r;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sd <= 1'b0;
        end else if (launch) begin
            // left slice wins where the two overlap
            sd <= active & (sl.hit ? sl.val : (sr.hit & sr.val));
        end
    end

    assert_idle_lane_R8: assert property (@(posedge clk) disable iff (rst)
        (!active && $past(!active)) |-> !sd);

    assert_sd_on_launch_R7: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && sd != $past(sd)) |-> $past(launch));

endmodule

// File: rtl/aud_frame_tx.sv
module aud_frame_tx
    import aftx_pkg::*;
#(
    parameter int NLANES = 4,
    localparam int BUS_W = NLANES * SMP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_en,
    input  logic               cfg_ws_start_high,
    input  logic               cfg_launch_rise,
    input  logic               cfg_ws_pulse,
    input  logic               cfg_lsb_first,
    input  logic               cfg_wide,
    input  logic               cfg_stereo,
    input  logic [1:0]         cfg_lanes,
    input  logic [POS_W-1:0]   cfg_left_pos,
    input  logic [POS_W-1:0]   cfg_right_pos,
    input  logic [IDX_W-1:0]   cfg_cut_idx,
    input  logic [LEN_W-1:0]   cfg_frame_len,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [BUS_W-1:0]   s_left,
    input  logic [BUS_W-1:0]   s_right,
    output logic               sck,
    output logic               ws,
    output logic [NLANES-1:0]  sd,
    output logic               cfg_err
);

    cfg_t             cfg;
    logic             run, launch, take;
    logic [LEN_W-1:0] nxt, cnt;

    assign cfg = '{ws_hi: cfg_ws_start_high, rise_launch: cfg_launch_rise,
                   ws_pulse: cfg_ws_pulse, lsb_first: cfg_lsb_first,
                   wide: cfg_wide, stereo: cfg_stereo, lanes: cfg_lanes,
                   lpos: cfg_left_pos, rpos: cfg_right_pos,
                   cut: cfg_cut_idx, flen: cfg_frame_len};

    assign cfg_err = cfg_frame_len < min_len(cfg);
    assign run     = tx_en & ~cfg_err;
    assign s_ready = launch & (nxt == '0);
    assign take    = s_ready & s_valid;

    aftx_timing u_timing (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .cfg    (cfg),
        .launch (launch),
        .nxt    (nxt),
        .cnt    (cnt),
        .ws     (ws),
        .sck    (sck)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        aftx_lane #(.LANE(g)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .launch (launch),
            .take   (take),
            .nxt    (nxt),
            .cfg    (cfg),
            .new_l  (s_left[g*SMP_W +: SMP_W]),
            .new_r  (s_right[g*SMP_W +: SMP_W]),
            .sd     (sd[g])
        );
    end

    assert_take_at_start_R10: assert property (@(posedge clk) disable iff (rst)
        take |=> (cnt == '0));

    assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && $past(cfg_err) && $stable(cfg_ws_start_high))
            |-> (ws == ~cfg_ws_start_high && sd == '0 && !s_ready));

endmodule

// File: tb/aud_frame_tx_tb.sv
module aud_frame_tx_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         tx_en = 0, pol = 0, ce = 0, pulse = 0, lsb = 0, wide = 0, stereo = 1;
    logic [1:0]   lanes = 0;
    logic [8:0]   lpos = 0, rpos = 0;
    logic [4:0]   cut = 0;
    logic [9:0]   flen = 10'd32;
    logic         s_valid = 0;
    logic         s_ready, sck, ws, cfg_err;
    logic [3:0]   sd;
    logic [31:0]  sl [4];
    logic [31:0]  sr [4];
    logic [127:0] s_left, s_right;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            s_left[i*32 +: 32]  = sl[i];
            s_right[i*32 +: 32] = sr[i];
        end
    end

    aud_frame_tx u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .cfg_ws_start_high(pol),
        .cfg_launch_rise(ce), .cfg_ws_pulse(pulse), .cfg_lsb_first(lsb),
        .cfg_wide(wide), .cfg_stereo(stereo), .cfg_lanes(lanes),
        .cfg_left_pos(lpos), .cfg_right_pos(rpos), .cfg_cut_idx(cut),
        .cfg_frame_len(flen), .s_valid(s_valid), .s_ready(s_ready),
        .s_left(s_left), .s_right(s_right), .sck(sck), .ws(ws), .sd(sd),
        .cfg_err(cfg_err)
    );

    int checks = 0, fails = 0, edge_viol = 0, frames_done = 0;
    bit finished = 0;

    // passive frame monitor
    logic [511:0] cap_sd [4];
    logic [511:0] cap_ws;
    logic prev_sck = 0, prev_ws_s = 1, prev_ws_raw = 1, started = 0;
    logic [3:0] prev_sd = 0;
    int pos = 0;

    always @(posedge clk) begin
        #1;
        if (tx_en && !rst) begin
            if ((sd !== prev_sd || ws !== prev_ws_raw) && sck !== ce) edge_viol++;
            if (sck !== prev_sck && sck === ~ce) begin
                if (ws === pol && prev_ws_s !== pol) begin
                    pos = 0;
                    started = 1;
                end else begin
                    pos = (pos < 511) ? pos + 1 : 511;
                end
                if (started) begin
                    for (int l = 0; l < 4; l++) cap_sd[l][pos] = sd[l];
                    cap_ws[pos] = ws;
                    if (pos == int'(flen) - 1) frames_done++;
                end
                prev_ws_s = ws;
            end
        end else begin
            started   = 0;
            prev_ws_s = ~pol;
        end
        prev_sck    = sck;
        prev_sd     = sd;
        prev_ws_raw = ws;
    end

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected bit from the slice rules
    function automatic logic slice_hit(logic [31:0] smp, int p0, int b, output logic v);
        int top = wide ? 31 : 15;
        for (int i = int'(cut); i <= top; i++) begin
            int p = lsb ? p0 + (i - int'(cut)) : p0 + (top - i);
            if (p == b) begin
                v = smp[i];
                return 1'b1;
            end
        end
        v = 1'b0;
        return 1'b0;
    endfunction

    function automatic logic exp_bit(int lane, int b);
        logic v;
        if (lane > int'(lanes)) return 1'b0;
        if (slice_hit(sl[lane], int'(lpos), b, v)) return v;
        if (slice_hit(stereo ? sr[lane] : sl[lane], int'(rpos), b, v)) return v;
        return 1'b0;
    endfunction

    function automatic logic exp_ws(int b);
        if (pulse) return (b == 0) ? pol : ~pol;
        return (b < int'(flen) / 2) ? pol : ~pol;
    endfunction

    task automatic check_frame(string req);
        for (int l = 0; l < 4; l++) begin
            int bad = -1;
            for (int b = int'(flen) - 1; b >= 0; b--)
                if (cap_sd[l][b] !== exp_bit(l, b)) bad = b;
            if (bad < 0) check(req, $sformatf("lane %0d frame", l), 0, 0);
            else check(req, $sformatf("lane %0d bit %0d", l, bad), cap_sd[l][bad], exp_bit(l, bad));
        end
        begin
            int bad = -1;
            for (int b = int'(flen) - 1; b >= 0; b--)
                if (cap_ws[b] !== exp_ws(b)) bad = b;
            if (bad < 0) check("R5", "ws pattern", 0, 0);
            else check(pulse ? "R6" : "R5", $sformatf("ws bit %0d", bad), cap_ws[bad], exp_ws(bad));
        end
    endtask

    task automatic wait_frame();
        int f0 = frames_done;
        while (frames_done == f0) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic push();
        s_valid = 1;
        do @(negedge clk); while (!s_ready);
        @(posedge clk);
        #1 s_valid = 0;
    endtask

    task automatic stop_tx();
        @(negedge clk);
        tx_en = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_and_check(string req);
        @(negedge clk);
        tx_en = 1;
        push();
        wait_frame();
        check_frame(req);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7", "idle ws", ws, 1);
        check("R7", "idle sck", sck, 0);
        check("R7", "idle sd", sd, 0);
        check("R10", "ready in reset idle", s_ready, 0);
        check("R11", "err at len 32", cfg_err, 0);
    endtask

    task automatic t_msb16();
        stop_tx();
        wide = 0; stereo = 1; lsb = 0; lanes = 0; cut = 4;
        lpos = 1; rpos = 20; flen = 40;
        sl[0] = 32'hFFFF_A5C3; sr[0] = 32'h0000_3C96;
        sl[1] = 32'h1234_5678; sr[1] = 32'h9ABC_DEF0;
        sl[2] = 32'hFFFF_FFFF; sr[2] = 32'hFFFF_FFFF;
        sl[3] = 32'hFFFF_FFFF; sr[3] = 32'hFFFF_FFFF;
        start_and_check("R1 R3 R4 R8");
        check("R7", "launch edge msb16", edge_viol, 0);
    endtask

    task automatic t_lsb32();
        stop_tx();
        wide = 1; stereo = 1; lsb = 1; lanes = 3; cut = 3;
        lpos = 0; rpos = 31; flen = 64;
        sl[0] = 32'hDEAD_BEEF; sr[0] = 32'h0F1E_2D3C;
        sl[1] = 32'h8000_0001; sr[1] = 32'h7FFF_FFFE;
        sl[2] = 32'hC3C3_5A5A; sr[2] = 32'h1111_8888;
        sl[3] = 32'hA0A0_0505; sr[3] = 32'hFEDC_BA98;
        start_and_check("R2 R4 R3");
    endtask

    task automatic t_repeat();
        // no offer: the next frame repeats the previous samples
        wait_frame();
        check_frame("R10 repeat");
        sl[0] = 32'h1357_9BDF; sr[0] = 32'h2468_ACE0;
        push();
        wait_frame();
        check_frame("R10 new");
    endtask

    task automatic t_mono();
        stop_tx();
        wide = 0; stereo = 0; lsb = 0; lanes = 1; cut = 10;
        lpos = 0; rpos = 7; flen = 13;
        sl[0] = 32'h0000_B6C0; sr[0] = 32'h0000_0000;
        sl[1] = 32'h0000_4BFF; sr[1] = 32'h0000_FFFF;
        start_and_check("R9 R3");
    endtask

    task automatic t_pulse();
        stop_tx();
        pol = 1; ce = 1; pulse = 1;
        @(negedge clk);
        check("R7", "idle sck with rise launch", sck, 1);
        check("R7", "idle ws start high", ws, 0);
        wide = 0; stereo = 1; lsb = 1; lanes = 2; cut = 0;
        lpos = 2; rpos = 20; flen = 48;
        sl[2] = 32'h0000_F00D; sr[2] = 32'h0000_0FF1;
        start_and_check("R6 R7 R2");
        check("R7", "launch edge pulse", edge_viol, 0);
    endtask

    task automatic t_err();
        stop_tx();
        pol = 0; ce = 0; pulse = 0;
        wide = 1; stereo = 1; lsb = 0; lanes = 0; cut = 28;
        lpos = 0; rpos = 18; flen = 35;
        @(negedge clk);
        tx_en = 1;
        s_valid = 1;
        begin
            int rdy = 0, busy = 0;
            repeat (100) begin
                @(negedge clk);
                if (s_ready) rdy++;
                if (ws !== 1'b1 || sd !== 4'b0) busy++;
            end
            check("R11", "err at 35 wide stereo", cfg_err, 1);
            check("R11", "ready while err", rdy, 0);
            check("R11", "activity while err", busy, 0);
        end
        s_valid = 0;
        stop_tx();
        wide = 0; stereo = 0; flen = 12;
        @(negedge clk);
        check("R11", "err at 12 mono", cfg_err, 1);
        flen = 13;
        @(negedge clk);
        check("R11", "no err at 13 mono", cfg_err, 0);
        wide = 1; stereo = 1; flen = 36;
        @(negedge clk);
        check("R11", "no err at 36 wide stereo", cfg_err, 0);
        sl[0] = 32'h9000_0000; sr[0] = 32'hA000_0000;
        start_and_check("R11 R1");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            sl[i] = '0;
            sr[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_msb16();
        t_lsb32();
        t_repeat();
        t_mono();
        t_pulse();
        t_err();
        check("R7", "launch edge overall", edge_viol, 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule